// File: doc/BRIEF.md
# Polling Active Exit Evaluator

This block decides when a multi-lane serial link leaves its first active training stage and which stage follows. A synchronous enter strobe starts an evaluation window. During that window the block counts the training ordered sets the local transmitter sends. For each lane it tracks runs of consecutive valid training sequences received and remembers whether the lane has left electrical idle. The receiver-detect mask, which an earlier stage finds, is captured on the enter strobe.

The block can exit early once enough sets have been sent and every detected lane has a full run of valid sequences. If that does not happen before a programmable timeout, a fallback rule applies: a programmable minimum number of detected lanes must have shown idle exit. This lets a link with broken lanes still train at reduced width. With the minimum set to 1, one healthy lane is enough. With the minimum set to the full width, a single dead lane makes training fail. The result is a single-cycle pulse on either the configuration output or the detect output.

Top module: `poll_active_exit`

## Requirements
- R1: With enter taken at clock edge E0, the early exit pulses `goConfig` in the cycle after the first cycle in which two conditions hold: at least `TS1_TX_MIN` transmit strobes have been counted, and every detected lane has a run of `CONSEC_TS` valid sequences. At least one lane must be detected. If transmit strobes and sequences start in the cycle after E0, the pulse comes TS1_TX_MIN+1 cycles after E0.
- R2: If fewer than `TS1_TX_MIN` transmit strobes arrive, the early exit never fires, even when every lane has full runs.
- R3: A lane's idle-exit flag sets on any cycle with its idle-exit input high while active. It stays set until the next enter, so a one-cycle pulse is remembered.
- R4: A lane whose run has reached `CONSEC_TS` counts as having left idle, even with no idle-exit input.
- R5: When the window expires (the cycle `TIMEOUT_MS*CLK_KHZ` cycles after E0), `goConfig` pulses in that cycle if the number of detected lanes that have left idle is at least `minLanes`. A value of 0 is treated as 1.
- R6: If neither exit condition holds at expiry, `goDetect` pulses in that same cycle instead.
- R7: Lanes whose bit in the captured mask is 0 are ignored by both conditions.
- R8: A lane's run counter returns to zero when its bad-sequence strobe is high. The bad strobe wins over a valid strobe in the same cycle. The counter saturates at `CONSEC_TS`, and strobes after a reset rebuild the run from zero.
- R9: The mask is sampled only on the enter strobe. Changes to `laneRxDet` afterwards have no effect until the next enter.
- R10: An enter strobe, even in the middle of a window, clears all counters, flags and the timer, and restarts the evaluation.
- R11: Each window produces exactly one output pulse of one cycle. The two outputs never pulse together, and nothing pulses after the exit until the next enter. After reset both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enterPoll | input | 1 | Starts or restarts the evaluation window; captures the mask |
| laneRxDet | input | NUM_LANES | Receiver-detected lanes from the detect stage |
| laneTsValid | input | NUM_LANES | Per-lane strobe: valid training sequence (or its complement) received |
| laneTsBad | input | NUM_LANES | Per-lane strobe: something other than a valid training sequence received |
| laneEiExit | input | NUM_LANES | Per-lane electrical-idle exit indication |
| txTs1Sent | input | 1 | Strobe for each training set sent by the local transmitter |
| minLanes | input | $clog2(NUM_LANES+1) | Minimum qualifying lane count for the timeout path |
| goConfig | output | 1 | One-cycle pulse: proceed to the configuration stage |
| goDetect | output | 1 | One-cycle pulse: return to the detect stage |

## Verification
A run counter or idle flag that is wrong in the internal state shows up at the ports in one of two ways. It can move the early `goConfig` pulse off its exact cycle (TS1_TX_MIN+1 after entry). It can also swap `goConfig` for `goDetect` at expiry, which is TIMEOUT_MS*CLK_KHZ cycles after entry. Every scenario therefore records the cycle and the count of each output pulse over a window that runs past expiry. A stale mask or a flag that enter failed to clear appears only at the next expiry, as the wrong output.

// File: rtl/pae_pkg.sv
package pae_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic clearAll;  // restart: zero counters, flags, timer; capture mask
    logic run;       // evaluation window open
  } dpCtrl_t;
endpackage

// File: rtl/pae_datapath.sv
module pae_datapath
  import pae_pkg::*;
#(
  parameter int NUM_LANES      = 8,
  parameter int CONSEC_TS      = 8,
  parameter int TS1_TX_MIN     = 1024,
  parameter int TIMEOUT_CYCLES = 6000000,
  localparam int CNT_W         = $clog2(NUM_LANES + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpCtrl_t              ctrl,
  input  logic [NUM_LANES-1:0] laneRxDet,
  input  logic [NUM_LANES-1:0] laneTsValid,
  input  logic [NUM_LANES-1:0] laneTsBad,
  input  logic [NUM_LANES-1:0] laneEiExit,
  input  logic                 txTs1Sent,
  output logic                 allTsDone,
  output logic                 anyDetected,
  output logic                 txDone,
  output logic                 timeoutHit,
  output logic [CNT_W-1:0]     eiCount
);
  localparam int TSC_W = $clog2(CONSEC_TS + 1);
  localparam int TX_W  = $clog2(TS1_TX_MIN + 1);
  localparam int TMR_W = $clog2(TIMEOUT_CYCLES + 1);

  logic [NUM_LANES-1:0] rxDetQ;
  logic [NUM_LANES-1:0] eiFlag;
  logic [NUM_LANES-1:0] tsDone;
  logic [NUM_LANES-1:0] qualify;
  logic [TSC_W-1:0]     tsCnt [NUM_LANES];
  logic [TX_W-1:0]      txCnt;
  logic [TMR_W-1:0]     timer;

  // receiver mask captured only on restart
  always_ff @(posedge clk) begin
    if (!rstN)              rxDetQ <= '0;
    else if (ctrl.clearAll) rxDetQ <= laneRxDet;
  end

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.clearAll |=> $stable(rxDetQ)); // R9

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    assign tsDone[i] = (tsCnt[i] == TSC_W'(CONSEC_TS));

    always_ff @(posedge clk) begin
      if (!rstN)              tsCnt[i] <= '0;
      else if (ctrl.clearAll) tsCnt[i] <= '0;
      else if (ctrl.run) begin
        if (laneTsBad[i])                    tsCnt[i] <= '0;
        else if (laneTsValid[i] && !tsDone[i]) tsCnt[i] <= tsCnt[i] + TSC_W'(1);
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN)                           eiFlag[i] <= 1'b0;
      else if (ctrl.clearAll)              eiFlag[i] <= 1'b0;
      else if (ctrl.run && laneEiExit[i])  eiFlag[i] <= 1'b1;
    end

    AST_BAD_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
      (ctrl.run && !ctrl.clearAll && laneTsBad[i]) |=> (tsCnt[i] == '0)); // R8
    AST_RUN_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
      tsCnt[i] <= TSC_W'(CONSEC_TS)); // R8
    AST_EI_STICKY: assert property (@(posedge clk) disable iff (!rstN)
      (eiFlag[i] && !ctrl.clearAll) |=> eiFlag[i]); // R3
  end

  assign qualify     = rxDetQ & (eiFlag | tsDone);
  assign allTsDone   = &(tsDone | ~rxDetQ);
  assign anyDetected = |rxDetQ;

  always_comb begin
    eiCount = '0;
    for (int i = 0; i < NUM_LANES; i++) eiCount = eiCount + CNT_W'(qualify[i]);
  end

  // transmitted-set counter, saturating at the threshold
  always_ff @(posedge clk) begin
    if (!rstN)              txCnt <= '0;
    else if (ctrl.clearAll) txCnt <= '0;
    else if (ctrl.run && txTs1Sent && !txDone) txCnt <= txCnt + TX_W'(1);
  end
  assign txDone = (txCnt == TX_W'(TS1_TX_MIN));

  AST_TX_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    txCnt <= TX_W'(TS1_TX_MIN)); // R1

  // window timer
  always_ff @(posedge clk) begin
    if (!rstN)              timer <= '0;
    else if (ctrl.clearAll) timer <= '0;
    else if (ctrl.run && !timeoutHit) timer <= timer + TMR_W'(1);
  end
  assign timeoutHit = ctrl.run && (timer == TMR_W'(TIMEOUT_CYCLES - 1));
endmodule

// File: rtl/pae_control.sv
module pae_control
  import pae_pkg::*;
#(
  parameter int NUM_LANES = 8,
  localparam int CNT_W    = $clog2(NUM_LANES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enterPoll,
  input  logic [CNT_W-1:0] minLanes,
  input  logic             allTsDone,
  input  logic             anyDetected,
  input  logic             txDone,
  input  logic             timeoutHit,
  input  logic [CNT_W-1:0] eiCount,
  output dpCtrl_t          ctrl,
  output logic             goConfig,
  output logic             goDetect
);
  logic             active;
  logic             earlyOk;
  logic             eiEnough;
  logic [CNT_W-1:0] minEff;

  assign minEff   = (minLanes == '0) ? CNT_W'(1) : minLanes;
  assign eiEnough = (eiCount >= minEff);
  assign earlyOk  = txDone && allTsDone && anyDetected;

  assign ctrl.clearAll = enterPoll;
  assign ctrl.run      = active;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active   <= 1'b0;
      goConfig <= 1'b0;
      goDetect <= 1'b0;
    end else begin
      goConfig <= 1'b0;
      goDetect <= 1'b0;
      if (enterPoll) begin
        active <= 1'b1;
      end else if (active) begin
        if (earlyOk) begin
          goConfig <= 1'b1;
          active   <= 1'b0;
        end else if (timeoutHit) begin
          if (eiEnough) goConfig <= 1'b1;
          else          goDetect <= 1'b1;
          active <= 1'b0;
        end
      end
    end
  end

  AST_NO_DUAL_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    !(goConfig && goDetect)); // R11
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (goConfig || goDetect) |=> !(goConfig || goDetect)); // R11
  AST_DETECT_ON_TIMEOUT: assert property (@(posedge clk) disable iff (!rstN)
    goDetect |-> $past(timeoutHit)); // R6
  AST_EXIT_CLOSES: assert property (@(posedge clk) disable iff (!rstN)
    ((goConfig || goDetect) && !$past(enterPoll)) |-> !active); // R11
endmodule

// File: rtl/poll_active_exit.sv
module poll_active_exit
  import pae_pkg::*;
#(
  parameter int NUM_LANES  = 8,
  parameter int CONSEC_TS  = 8,
  parameter int TS1_TX_MIN = 1024,
  parameter int CLK_KHZ    = 250000,
  parameter int TIMEOUT_MS = 24,
  localparam int TIMEOUT_CYCLES = TIMEOUT_MS * CLK_KHZ,
  localparam int CNT_W          = $clog2(NUM_LANES + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 enterPoll,
  input  logic [NUM_LANES-1:0] laneRxDet,
  input  logic [NUM_LANES-1:0] laneTsValid,
  input  logic [NUM_LANES-1:0] laneTsBad,
  input  logic [NUM_LANES-1:0] laneEiExit,
  input  logic                 txTs1Sent,
  input  logic [CNT_W-1:0]     minLanes,
  output logic                 goConfig,
  output logic                 goDetect
);
  dpCtrl_t          ctrl;
  logic             allTsDone;
  logic             anyDetected;
  logic             txDone;
  logic             timeoutHit;
  logic [CNT_W-1:0] eiCount;

  pae_datapath #(
    .NUM_LANES(NUM_LANES), .CONSEC_TS(CONSEC_TS),
    .TS1_TX_MIN(TS1_TX_MIN), .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
  ) dp_i (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .laneRxDet(laneRxDet), .laneTsValid(laneTsValid), .laneTsBad(laneTsBad),
    .laneEiExit(laneEiExit), .txTs1Sent(txTs1Sent),
    .allTsDone(allTsDone), .anyDetected(anyDetected), .txDone(txDone),
    .timeoutHit(timeoutHit), .eiCount(eiCount)
  );

  pae_control #(.NUM_LANES(NUM_LANES)) ctl_i (
    .clk(clk), .rstN(rstN), .enterPoll(enterPoll), .minLanes(minLanes),
    .allTsDone(allTsDone), .anyDetected(anyDetected), .txDone(txDone),
    .timeoutHit(timeoutHit), .eiCount(eiCount),
    .ctrl(ctrl), .goConfig(goConfig), .goDetect(goDetect)
  );
endmodule

// File: tb/poll_active_exit_tb_top.sv
module poll_active_exit_tb_top;
  localparam int NL    = 8;
  localparam int TXMIN = 16;
  localparam int KHZ   = 2;
  localparam int TMS   = 24;
  localparam int T     = TMS * KHZ;  // 48 cycles

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          enterPoll = 1'b0;
  logic [NL-1:0] laneRxDet = '0;
  logic [NL-1:0] laneTsValid = '0;
  logic [NL-1:0] laneTsBad = '0;
  logic [NL-1:0] laneEiExit = '0;
  logic          txTs1Sent = 1'b0;
  logic [3:0]    minLanes = '0;
  logic          goConfig;
  logic          goDetect;

  int cyc = 0, base = 0;
  int cfgCnt = 0, detCnt = 0, cfgCyc = -1, detCyc = -1;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (rstN) begin
    if (goConfig) begin cfgCnt++; cfgCyc = cyc - base; end
    if (goDetect) begin detCnt++; detCyc = cyc - base; end
  end

  poll_active_exit #(.NUM_LANES(NL), .CONSEC_TS(8), .TS1_TX_MIN(TXMIN),
                     .CLK_KHZ(KHZ), .TIMEOUT_MS(TMS)) dut_i (
    .clk(clk), .rstN(rstN), .enterPoll(enterPoll), .laneRxDet(laneRxDet),
    .laneTsValid(laneTsValid), .laneTsBad(laneTsBad), .laneEiExit(laneEiExit),
    .txTs1Sent(txTs1Sent), .minLanes(minLanes),
    .goConfig(goConfig), .goDetect(goDetect));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic enterPolling(logic [NL-1:0] mask, int minL);
    @(negedge clk);
    laneRxDet = mask; minLanes = 4'(minL); enterPoll = 1'b1;
    @(negedge clk);
    enterPoll = 1'b0;
    cfgCnt = 0; detCnt = 0; cfgCyc = -1; detCyc = -1;
    base = cyc;
  endtask

  task automatic drive(int n, logic [NL-1:0] v, logic [NL-1:0] b,
                       logic [NL-1:0] e, bit tx);
    laneTsValid = v; laneTsBad = b; laneEiExit = e; txTs1Sent = tx;
    repeat (n) @(negedge clk);
    laneTsValid = '0; laneTsBad = '0; laneEiExit = '0; txTs1Sent = 1'b0;
  endtask

  task automatic settle();
    while (cyc < base + T + 4) @(negedge clk);
  endtask

  task automatic expectConfig(string tag, int at);
    settle();
    chk({tag, " config count"}, cfgCnt, 1);
    chk({tag, " config cycle"}, cfgCyc, at);
    chk({tag, " detect count"}, detCnt, 0);
  endtask

  task automatic expectDetect(string tag);
    settle();
    chk({tag, " detect count"}, detCnt, 1);
    chk({tag, " detect cycle"}, detCyc, T);
    chk({tag, " config count"}, cfgCnt, 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R11 reset goConfig", int'(goConfig), 0);
    chk("R11 reset goDetect", int'(goDetect), 0);
  endtask

  task automatic t_early();  // R1, R8 saturation, R11 silence after exit
    enterPolling(8'hFF, 8);
    drive(TXMIN, 8'hFF, 8'h00, 8'h00, 1'b1);
    expectConfig("R1 early", TXMIN + 1);
  endtask

  task automatic t_shortTx();  // R2, R4
    enterPolling(8'hFF, 8);
    drive(TXMIN - 1, 8'hFF, 8'h00, 8'h00, 1'b1);
    expectConfig("R2 R4 short tx", T);
  endtask

  task automatic t_brokenFull();  // R6
    enterPolling(8'hFF, 8);
    drive(TXMIN, 8'h00, 8'h00, 8'h7F, 1'b1);
    expectDetect("R6 broken lane full width");
  endtask

  task automatic t_brokenOne();  // R5
    enterPolling(8'hFF, 1);
    drive(TXMIN, 8'h00, 8'h00, 8'h7F, 1'b1);
    expectConfig("R5 broken lane min1", T);
  endtask

  task automatic t_minZero();  // R5 zero treated as one
    enterPolling(8'hFF, 0);
    drive(1, 8'h00, 8'h00, 8'h08, 1'b0);
    expectConfig("R5 min zero", T);
  endtask

  task automatic t_undetected();  // R7
    enterPolling(8'h7F, 8);
    drive(TXMIN, 8'h7F, 8'h00, 8'h00, 1'b1);
    expectConfig("R7 undetected lane", TXMIN + 1);
  endtask

  task automatic t_badNoRecover();  // R8
    enterPolling(8'hFF, 8);
    drive(7, 8'hFF, 8'h00, 8'h00, 1'b1);
    drive(1, 8'hFF, 8'h01, 8'h00, 1'b1);  // bad wins over valid on lane 0
    drive(8, 8'hFE, 8'h00, 8'h00, 1'b1);
    expectDetect("R8 bad resets run");
  endtask

  task automatic t_badRecover();  // R8
    enterPolling(8'hFF, 8);
    drive(7, 8'hFF, 8'h00, 8'h00, 1'b1);
    drive(1, 8'hFE, 8'h01, 8'h00, 1'b1);
    drive(8, 8'hFF, 8'h00, 8'h00, 1'b1);
    expectConfig("R8 run rebuilt", TXMIN + 1);
  endtask

  task automatic t_sticky();  // R3
    enterPolling(8'hFF, 8);
    drive(3, 8'h00, 8'h00, 8'h00, 1'b0);
    drive(1, 8'h00, 8'h00, 8'hFF, 1'b0);
    expectConfig("R3 sticky idle exit", T);
  endtask

  task automatic t_maskLatch();  // R9
    enterPolling(8'h0F, 8);
    laneRxDet = 8'hFF;
    drive(TXMIN, 8'h0F, 8'h00, 8'h00, 1'b1);
    expectConfig("R9 mask captured", TXMIN + 1);
    laneRxDet = '0;
  endtask

  task automatic t_restart();  // R10
    enterPolling(8'hFF, 8);
    drive(2, 8'hFF, 8'h00, 8'hFF, 1'b1);
    repeat (5) @(negedge clk);
    enterPolling(8'hFF, 8);
    expectDetect("R10 restart clears");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_early();
    t_shortTx();
    t_brokenFull();
    t_brokenOne();
    t_minZero();
    t_undetected();
    t_badNoRecover();
    t_badRecover();
    t_sticky();
    t_maskLatch();
    t_restart();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule